// File: doc/BRIEF.md
# Phase-Accumulator PWM Generator with Staged Configuration

This block drives one pulse-width-modulated output pin from a fixed reference clock. The period comes from a phase accumulator: on every clock it adds a programmable step, the base unit, to a BU_W-bit running phase. One wrap of that phase is one PWM period, so the output frequency is base_unit × f_clk / 2^BU_W. The duty is set by an 8-bit on-time divisor that works inversely. The pin is high while the top 8 bits of the phase are at or above the divisor. A divisor of 0 keeps the pin high almost all the time, and larger values shorten the high time.

Software sees one 32-bit control word through a plain write strobe and a read-back bus. New base-unit and divisor values land in staging registers and do not touch the running generator until software raises the update bit. That request takes effect at the next phase wrap while the generator runs, or on the next clock while it is stopped. The update bit then drops by itself. The expected sequence is: write the values with the update bit set while stopped, then set the enable bit. This way the first enabled period already uses the new values.

Top module: `pwm_accum_gen`

## Requirements
- R1: Control word layout is: bit 31 enable, bit 30 update request, bits [8 +: BU_W] base unit, bits [7:0] on-time divisor. A write updates the enable bit, the staged base unit and the staged divisor on the next clock, and the read-back bus shows them exactly as written. Writing 1 to bit 30 makes bit 30 read 1 until the request is committed.
- R2: The output is registered. It goes high one clock after the accumulator's top 8 bits are greater than or equal to the active divisor, and low otherwise. Divisor 0 keeps it high on every enabled cycle. Divisor 255 keeps it low whenever the top 8 bits never reach 255.
- R3: While enabled, the accumulator advances by the active base unit on every clock, modulo 2^BU_W, so the output period is 2^BU_W / base_unit clocks when that ratio is an integer.
- R4: Base-unit and divisor writes without the update bit leave the running output unchanged, while the read-back bus already shows the new values.
- R5: A pending update is committed at the next accumulator wrap while enabled, or at the next clock while disabled. After the commit, bit 30 reads 0 and the generator uses the staged values.
- R6: While enable is clear, the accumulator is held at zero and the output is low from the second clock on. After re-enabling, the phase restarts from zero.
- R7: When BU_W < 22, control bits 29 down to 8+BU_W are ignored and read back as 0.
- R8: If a write lands on the same clock as a commit, the commit moves the staged values held before that clock. The write's fields become the new staged values, and the write's bit 30 alone decides whether an update is pending afterwards.
- R9: Synchronous active-high reset clears the control word to zero and drives the output low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Control word read-back |
| pwm_out | output | 1 | Registered PWM output pin |

## Verification
The two functions that can meet on one clock edge are a software write and the hardware commit of a pending update. With the generator stopped, two writes are issued back to back. The first sets the update bit, and the second, with different values and the update bit clear, lands exactly on the clock where the stopped generator commits. The read-back bus must then show the second values with no pending request. After enabling without a new update, the measured period and high count must match the first values, not the second.

// File: rtl/pwm_acc_pkg.sv
package pwm_acc_pkg;
  localparam int EN_BIT    = 31;
  localparam int UPD_BIT   = 30;
  localparam int BU_LSB    = 8;
  localparam int DIV_W     = 8;
  localparam int BU_MAX_W  = 22;
endpackage

// File: rtl/pwm_acc_cfg.sv
module pwm_acc_cfg
  import pwm_acc_pkg::*;
#(
  parameter int BU_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [31:0]           wr_data,
  input  logic                  wrap_i,
  output logic                  en_o,
  output logic [BU_W-1:0]       act_bu_o,
  output logic [DIV_W-1:0]      act_div_o,
  output logic [31:0]           rd_data_o
);
  localparam int PAD = BU_MAX_W - BU_W;

  logic              en_q, pend_q;
  logic [BU_W-1:0]   sh_bu_q, act_bu_q;
  logic [DIV_W-1:0]  sh_div_q, act_div_q;
  logic              commit;

  assign commit = pend_q && (!en_q || wrap_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= 1'b0;
      pend_q    <= 1'b0;
      sh_bu_q   <= '0;
      sh_div_q  <= '0;
      act_bu_q  <= '0;
      act_div_q <= '0;
    end else begin
      if (wr_en) begin
        en_q     <= wr_data[EN_BIT];
        sh_bu_q  <= wr_data[BU_LSB +: BU_W];
        sh_div_q <= wr_data[DIV_W-1:0];
      end
      if (commit) begin
        act_bu_q  <= sh_bu_q;
        act_div_q <= sh_div_q;
      end
      if (wr_en && wr_data[UPD_BIT])
        pend_q <= 1'b1;
      else if (commit)
        pend_q <= 1'b0;
    end
  end

  generate
    if (PAD > 0) begin : g_pad
      logic unused_hi;
      assign unused_hi = ^wr_data[UPD_BIT-1:BU_LSB+BU_W];
      assign rd_data_o = {en_q, pend_q, {PAD{1'b0}}, sh_bu_q, sh_div_q};
    end else begin : g_full
      assign rd_data_o = {en_q, pend_q, sh_bu_q, sh_div_q};
    end
  endgenerate

  assign en_o      = en_q;
  assign act_bu_o  = act_bu_q;
  assign act_div_o = act_div_q;

  // R1: an update request is visible on the next clock
  p_upd_set_r1: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_data[UPD_BIT] |=> rd_data_o[UPD_BIT]);

  // R5: a stopped generator commits on the next clock
  p_idle_commit_r5: assert property (@(posedge clk) disable iff (rst)
    pend_q && !en_q && !(wr_en && wr_data[UPD_BIT]) |=> !pend_q);

  // R4: with nothing pending the running settings hold
  p_shadow_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !pend_q |=> $stable(act_bu_q) && $stable(act_div_q));
endmodule

// File: rtl/pwm_acc_core.sv
module pwm_acc_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  input  logic [W-1:0] step_i,
  output logic [W-1:0] acc_o,
  output logic         wrap_o
);
  logic [W-1:0] acc_q;
  logic [W:0]   sum;

  assign sum    = {1'b0, acc_q} + {1'b0, step_i};
  assign wrap_o = en_i && sum[W];

  always_ff @(posedge clk) begin
    if (rst)        acc_q <= '0;
    else if (en_i)  acc_q <= sum[W-1:0];
    else            acc_q <= '0;
  end

  assign acc_o = acc_q;

  // R3: after a wrap the phase lands below the step that carried it over
  p_wrap_lands_low_r3: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> acc_q < $past(step_i));
endmodule

// File: rtl/pwm_acc_duty.sv
module pwm_acc_duty #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic [DW-1:0] phase_hi_i,
  input  logic [DW-1:0] div_i,
  output logic          pwm_o
);
  logic pwm_q;

  always_ff @(posedge clk) begin
    if (rst) pwm_q <= 1'b0;
    else     pwm_q <= en_i && (phase_hi_i >= div_i);
  end

  assign pwm_o = pwm_q;
endmodule

// File: rtl/pwm_accum_gen.sv
module pwm_accum_gen
  import pwm_acc_pkg::*;
#(
  parameter int BU_W = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        pwm_out
);
  logic              en;
  logic              wrap;
  logic [BU_W-1:0]   act_bu;
  logic [DIV_W-1:0]  act_div;
  logic [BU_W-1:0]   acc;

  pwm_acc_cfg #(.BU_W(BU_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .wrap_i(wrap), .en_o(en), .act_bu_o(act_bu), .act_div_o(act_div),
    .rd_data_o(rd_data)
  );

  pwm_acc_core #(.W(BU_W)) u_core (
    .clk(clk), .rst(rst), .en_i(en), .step_i(act_bu),
    .acc_o(acc), .wrap_o(wrap)
  );

  pwm_acc_duty #(.DW(DIV_W)) u_duty (
    .clk(clk), .rst(rst), .en_i(en), .phase_hi_i(acc[BU_W-1 -: DIV_W]),
    .div_i(act_div), .pwm_o(pwm_out)
  );

  // R6: two stopped clocks keep the pin low
  p_idle_low_r6: assert property (@(posedge clk) disable iff (rst)
    !en && $past(!en) |-> !pwm_out);

  // R2: divisor zero means high on every enabled cycle
  p_full_on_r2: assert property (@(posedge clk) disable iff (rst)
    $past(en) && ($past(act_div) == '0) |-> pwm_out);
endmodule

// File: tb/pwm_accum_gen_tb.sv
`timescale 1ns/1ps
module pwm_accum_gen_tb;
  localparam int BU_W = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        pwm_out;

  always #2 clk = ~clk;

  pwm_accum_gen #(.BU_W(BU_W)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pwm_out(pwm_out)
  );

  typedef struct { string tag; logic [31:0] val; } item_t;
  item_t       exp_q[$];
  logic [31:0] act_q[$];
  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic expect_item(input string tag, input logic [31:0] e, input logic [31:0] a);
    item_t it;
    it.tag = tag; it.val = e;
    exp_q.push_back(it);
    act_q.push_back(a);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0 && act_q.size() > 0) begin
        item_t it;
        logic [31:0] a;
        it = exp_q.pop_front();
        a  = act_q.pop_front();
        n_vec++;
        if (a !== it.val) begin
          n_bad++;
          $display("FAIL %s actual=0x%0h expected=0x%0h", it.tag, a, it.val);
        end
      end
    end
  end

  function automatic logic [31:0] mk(input bit en, input bit upd,
                                     input logic [15:0] bu, input logic [7:0] dv);
    return {en, upd, 6'b0, bu, dv};
  endfunction

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // samples 3*n cycles; high count over the first n, distance of first two rises
  task automatic measure(input int n, output int high, output int per);
    int first_r = -1;
    logic prev;
    high = 0; per = 0;
    prev = pwm_out;
    for (int i = 0; i < 3*n; i++) begin
      @(negedge clk);
      if (i < n && pwm_out) high++;
      if (pwm_out && !prev) begin
        if (first_r < 0) first_r = i;
        else if (per == 0) per = i - first_r;
      end
      prev = pwm_out;
    end
  endtask

  task automatic run_cfg(input logic [15:0] bu, input logic [7:0] dv, input string tag);
    wr(mk(0, 1, bu, dv));
    expect_item({tag, " R5 update pending while stopped"}, 32'h1, {31'b0, rd_data[30]});
    wr(mk(1, 0, bu, dv));
    expect_item({tag, " R5 update committed"}, 32'h0, {31'b0, rd_data[30]});
    repeat (3) @(negedge clk);
  endtask

  initial begin : driver
    int h, p, j;
    repeat (3) @(negedge clk);
    // R9 reset state
    expect_item("R9 rd_data after reset", 32'h0, rd_data);
    expect_item("R9 pwm_out after reset", 32'h0, {31'b0, pwm_out});
    @(negedge clk); rst = 1'b0;

    // R1 read-back of fields
    wr(mk(0, 0, 16'h1234, 8'h80));
    expect_item("R1 readback", 32'h0012_3480, rd_data);
    // R7 bits above the base-unit field ignored
    wr(32'h3F12_3480);
    expect_item("R7 high bits read as zero", 32'h0012_3480, rd_data);

    // R2/R3 base 4096 -> 16-cycle period, divisor 128 -> 8 high
    run_cfg(16'd4096, 8'd128, "cfgA");
    measure(16, h, p);
    expect_item("R2 high count bu4096 div128", 8, h);
    expect_item("R3 period bu4096", 16, p);

    run_cfg(16'd4096, 8'd0, "cfgB");
    measure(16, h, p);
    expect_item("R2 div0 always high", 16, h);

    run_cfg(16'd4096, 8'd255, "cfgC");
    measure(16, h, p);
    expect_item("R2 div255 never high", 0, h);

    run_cfg(16'd4096, 8'd100, "cfgD");
    measure(16, h, p);
    expect_item("R2 high count div100", 9, h);

    run_cfg(16'd8192, 8'd64, "cfgE");
    measure(8, h, p);
    expect_item("R2 high count bu8192 div64", 6, h);
    expect_item("R3 period bu8192", 8, p);

    // R4 staged write while running leaves output alone
    run_cfg(16'd4096, 8'd128, "cfgF");
    wr(mk(1, 0, 16'd2048, 8'd64));
    expect_item("R1 readback of staged values", mk(1, 0, 16'd2048, 8'd64), rd_data);
    measure(16, h, p);
    expect_item("R4 high count unchanged", 8, h);
    expect_item("R4 period unchanged", 16, p);

    // R5 update while running commits at wrap
    wr(mk(1, 1, 16'd2048, 8'd64));
    expect_item("R5 pending while running", 32'h1, {31'b0, rd_data[30]});
    repeat (20) @(negedge clk);
    expect_item("R5 pending cleared after wrap", 32'h0, {31'b0, rd_data[30]});
    measure(32, h, p);
    expect_item("R5 new high count", 24, h);
    expect_item("R5 new period", 32, p);

    // R6 disabled output low
    wr(mk(0, 0, 16'd2048, 8'd64));
    @(negedge clk);
    measure(20, h, p);
    expect_item("R6 low while disabled", 0, h);
    // R6 phase restarts from zero: first high on 9th sample
    wr(mk(1, 0, 16'd2048, 8'd64));
    j = 0;
    for (int i = 1; i <= 64; i++) begin
      @(negedge clk);
      if (pwm_out && j == 0) j = i;
    end
    expect_item("R6 restart phase zero first high", 9, j);

    // R8 write landing on the commit clock
    wr(mk(0, 0, 16'd2048, 8'd64));
    @(negedge clk); wr_en = 1'b1; wr_data = mk(0, 1, 16'd8192, 8'd64);
    @(negedge clk); wr_data = mk(0, 0, 16'd4096, 8'd200);
    @(negedge clk); wr_en = 1'b0;
    expect_item("R8 readback after collision", mk(0, 0, 16'd4096, 8'd200), rd_data);
    wr(mk(1, 0, 16'd4096, 8'd200));
    repeat (3) @(negedge clk);
    measure(8, h, p);
    expect_item("R8 high count uses first values", 6, h);
    expect_item("R8 period uses first values", 8, p);

    repeat (4) @(negedge clk);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule